// File: doc/BRIEF.md
# Byte-Serial Carry-Chained Shift Unit

This block shifts or rotates an operand of one to four bytes by one bit position. It uses a single 8-bit datapath and a carry flag, and works through one byte per clock. A start pulse loads the whole operand into a register array. A sequencer then visits the selected bytes one at a time.

The first byte visited gets the requested operation. Every later byte is rotated through the carry flag, so the bit that leaves one byte enters the next. A left operation walks from the least significant byte upward. A right operation walks from the most significant byte downward, so an arithmetic right shift sees the sign byte first.

Each byte is written back in place, and the final carry is kept in a register. The result and the carry stay on the outputs until the next accepted start.

Top module: `byteshift_unit`

## Requirements
- R1: After a synchronous reset, `result_o` is all zero, `carry_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: Operation codes on `op_i` are 0 = logical shift, 1 = arithmetic shift, 2 = rotate through carry, 3 = logical shift. `dir_i` 0 means left and 1 means right. Any left shift (code 0, 1 or 3) moves every bit one place up, fills bit 0 with zero and puts the old top bit into the carry. For one byte: 0x7F gives 0xFE with carry 0, and 0x80 gives 0x00 with carry 1.
- R3: A logical right shift (code 0 or 3) fills the top bit with zero and puts the old bit 0 into the carry. For one byte: 0x80 gives 0x40 with carry 0, and 0x7F gives 0x3F with carry 1.
- R4: An arithmetic right shift copies the top bit of the operand into the vacated bit, so a negative value stays negative. For one byte: 0x80 gives 0xC0 with carry 0, and 0x7F gives 0x3F with carry 1.
- R5: A rotate (code 2) fills the vacated bit from `carry_i`, which is sampled with the start. A shift never uses `carry_i`.
- R6: For a count of n bytes, the bytes `operand_i[8n-1:0]` behave as one 8n-bit value. The first byte processed is shifted and each later byte is rotated through the carry, so bits cross byte boundaries.
- R7: Bytes at or above position n keep the values loaded from `operand_i`.
- R8: `nbytes_i` is 3 bits wide. A value of 0 acts as 1, and values above 4 act as 4.
- R9: After an accepted start, `busy_o` is high for exactly n cycles. `done_o` then pulses high for one cycle, and the result and carry are valid in that same cycle.
- R10: A start asserted while `busy_o` is high is ignored. Its operand, operation, count and carry have no effect on the running job.
- R11: While idle with no start, `result_o` and `carry_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a job; accepted only while idle |
| op_i | input | 2 | Operation code (see R2) |
| dir_i | input | 1 | 0 = left, 1 = right |
| nbytes_i | input | 3 | Byte count 1..4 (see R8) |
| carry_i | input | 1 | Initial carry used by rotates |
| operand_i | input | 32 | Operand; byte 0 is least significant |
| result_o | output | 32 | Registered result bytes |
| carry_o | output | 1 | Registered carry flag |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default four byte lanes and 8-bit bytes, which gives a 3-bit count port. That width lets the bench drive counts 0, 5, 6 and 7 as well as 1 to 4, so both clamping rules of R8 can be reached. With four lanes, operands of every length up to the maximum are possible. The bench loads bytes above the count with distinctive values to show they are left alone. A reference model works on the whole multi-byte value at once and is compared against the byte-by-byte result. Extra start pulses are sent in the middle of a job.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SK_LOGIC  = 2'd0,
    SK_ARITH  = 2'd1,
    SK_ROTATE = 2'd2,
    SK_SPARE  = 2'd3
  } shf_kind_e;

  typedef enum logic {
    SD_LEFT  = 1'b0,
    SD_RIGHT = 1'b1
  } shf_dir_e;

  typedef struct packed {
    shf_kind_e kind;
    shf_dir_e  dir;
  } shf_cmd_t;

  function automatic shf_cmd_t make_cmd(input logic [1:0] kind_bits, input logic dir_bit);
    shf_cmd_t c;
    c.kind = shf_kind_e'(kind_bits);
    c.dir  = shf_dir_e'(dir_bit);
    return c;
  endfunction

endpackage

// File: rtl/shf_byte_alu.sv
// Single-byte shift/rotate stage. The first byte of a job uses the
// requested operation; every later byte rotates through the carry.
module shf_byte_alu
  import shf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              carry_i,
  input  logic              first_i,
  input  shf_cmd_t          cmd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              carry_o
);

  logic use_rot;
  logic fill;

  always_comb begin
    use_rot = (cmd_i.kind == SK_ROTATE) || !first_i;
    fill    = 1'b0;
    if (cmd_i.dir == SD_LEFT) begin
      if (use_rot) fill = carry_i;
      byte_o  = {byte_i[BYTE_W-2:0], fill};
      carry_o = byte_i[BYTE_W-1];
    end else begin
      if (use_rot)                      fill = carry_i;
      else if (cmd_i.kind == SK_ARITH)  fill = byte_i[BYTE_W-1];
      byte_o  = {fill, byte_i[BYTE_W-1:1]};
      carry_o = byte_i[0];
    end
  end

endmodule

// File: rtl/shf_bytefile.sv
// Register array holding the operand bytes: bulk load, one write per
// cycle, asynchronous read of one lane, and all lanes brought out.
module shf_bytefile #(
  parameter int N_BYTES = 4,
  parameter int BYTE_W  = 8,
  localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
  localparam int TOT_W  = N_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [TOT_W-1:0]  load_data_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [TOT_W-1:0]  all_o
);

  logic [BYTE_W-1:0] lane_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[g] <= '0;
      end else if (load_i) begin
        lane_q[g] <= load_data_i[g*BYTE_W +: BYTE_W];
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        lane_q[g] <= wr_data_i;
      end
    end
    assign all_o[g*BYTE_W +: BYTE_W] = lane_q[g];
  end

  assign rd_data_o = lane_q[rd_idx_i];

endmodule

// File: rtl/shf_seq.sv
// Walks the selected byte lanes: upward for left jobs, downward for
// right jobs, one lane per cycle, then pulses done.
module shf_seq #(
  parameter int N_BYTES = 4,
  parameter int CNT_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             dir_right_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             first_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [CNT_W-1:0] eff_n;
  logic [CNT_W-1:0] left_q;
  logic             down_q;

  always_comb begin
    if (nbytes_i == '0)                    eff_n = CNT_W'(1);
    else if (nbytes_i > CNT_W'(N_BYTES))   eff_n = CNT_W'(N_BYTES);
    else                                   eff_n = nbytes_i;
  end

  assign accept_o = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      first_o <= 1'b0;
      done_o  <= 1'b0;
      left_q  <= '0;
      idx_o   <= '0;
      down_q  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        busy_o  <= 1'b1;
        first_o <= 1'b1;
        left_q  <= eff_n;
        down_q  <= dir_right_i;
        idx_o   <= dir_right_i ? IDX_W'(eff_n - CNT_W'(1)) : '0;
      end else if (busy_o) begin
        first_o <= 1'b0;
        left_q  <= left_q - CNT_W'(1);
        idx_o   <= down_q ? (idx_o - IDX_W'(1)) : (idx_o + IDX_W'(1));
        if (left_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/byteshift_unit.sv
module byteshift_unit
  import shf_pkg::*;
#(
  parameter int N_BYTES = 4,
  parameter int BYTE_W  = 8,
  localparam int CNT_W  = $clog2(N_BYTES + 1),
  localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
  localparam int TOT_W  = N_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             carry_i,
  input  logic [TOT_W-1:0] operand_i,
  output logic [TOT_W-1:0] result_o,
  output logic             carry_o,
  output logic             busy_o,
  output logic             done_o
);

  logic              accept;
  logic              first;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] alu_byte;
  logic              alu_carry;
  shf_cmd_t          cmd_q;
  logic              carry_q;

  shf_seq #(
    .N_BYTES(N_BYTES),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .nbytes_i   (nbytes_i),
    .dir_right_i(dir_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .first_o    (first),
    .done_o     (done_o),
    .idx_o      (idx)
  );

  shf_bytefile #(
    .N_BYTES(N_BYTES),
    .BYTE_W (BYTE_W)
  ) u_file (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .load_data_i(operand_i),
    .wr_en_i    (busy_o),
    .wr_idx_i   (idx),
    .wr_data_i  (alu_byte),
    .rd_idx_i   (idx),
    .rd_data_o  (rd_byte),
    .all_o      (result_o)
  );

  shf_byte_alu #(
    .BYTE_W(BYTE_W)
  ) u_alu (
    .byte_i (rd_byte),
    .carry_i(carry_q),
    .first_i(first),
    .cmd_i  (cmd_q),
    .byte_o (alu_byte),
    .carry_o(alu_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= make_cmd(2'd0, 1'b0);
      carry_q <= 1'b0;
    end else if (accept) begin
      cmd_q   <= make_cmd(op_i, dir_i);
      carry_q <= carry_i;
    end else if (busy_o) begin
      carry_q <= alu_carry;
    end
  end

  assign carry_o = carry_q;

endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
  parameter int N_BYTES = 4,
  parameter int BYTE_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start_i,
  input logic                      busy_o,
  input logic                      done_o,
  input logic                      carry_o,
  input logic [N_BYTES*BYTE_W-1:0] result_o
);

  logic [7:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)         busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 8'd1;
    else             busy_len <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !carry_o && result_o == '0)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R9

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (busy_len < 8'(N_BYTES))); // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(carry_o))); // R11

endmodule

bind byteshift_unit shf_checker #(
  .N_BYTES(N_BYTES),
  .BYTE_W (BYTE_W)
) u_shf_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .carry_o (carry_o),
  .result_o(result_o)
);

// File: tb/tb_byteshift_unit.sv
module tb_byteshift_unit;

  localparam int NB = 4;
  localparam int BW = 8;
  localparam int TW = NB * BW;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic          dir_i = 1'b0;
  logic [CW-1:0] nbytes_i = '0;
  logic          carry_i = 1'b0;
  logic [TW-1:0] operand_i = '0;
  logic [TW-1:0] result_o;
  logic          carry_o, busy_o, done_o;

  int total = 0;
  int bad = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  typedef struct {
    logic [TW-1:0] res;
    logic          c;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  byteshift_unit #(.N_BYTES(NB), .BYTE_W(BW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .dir_i(dir_i),
    .nbytes_i(nbytes_i), .carry_i(carry_i), .operand_i(operand_i),
    .result_o(result_o), .carry_o(carry_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [TW-1:0] act, input logic [TW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int eff_count(input logic [CW-1:0] n);
    if (n == 0) return 1;
    if (int'(n) > NB) return NB;
    return int'(n);
  endfunction

  // Whole-value reference: treats the selected bytes as one wide word.
  function automatic void model(input logic [1:0] op, input logic dir,
                                input logic [CW-1:0] n, input logic cin,
                                input logic [TW-1:0] opd,
                                output logic [TW-1:0] res, output logic cout);
    int top;
    logic fill;
    logic [TW-1:0] v;
    top = eff_count(n) * BW - 1;
    v = opd;
    if (!dir) begin
      cout = v[top];
      for (int i = TW - 1; i > 0; i--) if (i <= top) v[i] = v[i-1];
      v[0] = (op == 2'd2) ? cin : 1'b0;
    end else begin
      cout = v[0];
      fill = (op == 2'd2) ? cin : ((op == 2'd1) ? v[top] : 1'b0);
      for (int i = 0; i < TW - 1; i++) if (i < top) v[i] = v[i+1];
      v[top] = fill;
    end
    res = v;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "done without job", {31'd0, done_o}, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result_o == e.res, e.req, "result", result_o, e.res);
        chk(carry_o == e.c, e.req, "carry", {31'd0, carry_o}, {31'd0, e.c});
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input logic dir, input logic [CW-1:0] n,
                        input logic cin, input logic [TW-1:0] opd,
                        input string req, input bit poke);
    exp_t e;
    int cnt;
    logic [TW-1:0] r;
    logic c;
    model(op, dir, n, cin, opd, r, c);
    e.res = r; e.c = c; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    op_i = op; dir_i = dir; nbytes_i = n; carry_i = cin; operand_i = opd;
    start_i = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        if (poke) begin  // R10: start while busy, different fields
          op_i = ~op; dir_i = ~dir; nbytes_i = 3'd4; carry_i = ~cin;
          operand_i = ~opd;
        end else begin
          start_i = 1'b0;
        end
      end else begin
        start_i = 1'b0;
      end
    end while (!done_o && cnt < 40);
    chk(cnt == eff_count(n) + 1, "R9", "cycles to done",
        TW'(cnt), TW'(eff_count(n) + 1));
    @(negedge clk);
    chk(!done_o, "R9", "done width", {31'd0, done_o}, '0);
    repeat (3) @(negedge clk);
    chk(result_o == r && carry_o == c, "R11", "hold after done",
        result_o, r);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(result_o == '0, "R1", "result", result_o, '0);
    chk(carry_o == 1'b0, "R1", "carry", {31'd0, carry_o}, '0);
    chk(!busy_o && !done_o, "R1", "busy/done", {30'd0, busy_o, done_o}, '0);
    rst = 1'b0;
    @(negedge clk);

    // Single byte, upper bytes loaded with markers (R7)
    run_op(2'd0, 1'b0, 3'd1, 1'b1, 32'hA5C3_3C7F, "R2", 1'b0);
    run_op(2'd0, 1'b0, 3'd1, 1'b1, 32'h5A11_2280, "R2", 1'b0);
    run_op(2'd1, 1'b0, 3'd1, 1'b0, 32'h0000_0080, "R2", 1'b0);
    run_op(2'd0, 1'b1, 3'd1, 1'b1, 32'hFFFF_FF80, "R3", 1'b0);
    run_op(2'd3, 1'b1, 3'd1, 1'b0, 32'h0000_007F, "R3", 1'b0);
    run_op(2'd1, 1'b1, 3'd1, 1'b0, 32'h1234_5680, "R4", 1'b0);
    run_op(2'd1, 1'b1, 3'd1, 1'b1, 32'h0000_007F, "R4", 1'b0);
    run_op(2'd2, 1'b0, 3'd1, 1'b1, 32'h0000_0080, "R5", 1'b0);
    run_op(2'd2, 1'b1, 3'd1, 1'b1, 32'h0000_0001, "R5", 1'b0);
    run_op(2'd2, 1'b1, 3'd1, 1'b0, 32'h0000_0001, "R5", 1'b0);

    // Multi-byte: carry crosses bytes
    run_op(2'd0, 1'b0, 3'd2, 1'b0, 32'hEEEE_0080, "R6", 1'b0);
    run_op(2'd1, 1'b1, 3'd4, 1'b0, 32'h8000_0001, "R6", 1'b0);
    run_op(2'd0, 1'b1, 3'd3, 1'b1, 32'h77_8001_00, "R6", 1'b0);
    run_op(2'd2, 1'b0, 3'd4, 1'b1, 32'h8080_8080, "R6", 1'b0);
    run_op(2'd1, 1'b1, 3'd2, 1'b0, 32'h1234_8100, "R7", 1'b0);

    // Count clamping
    run_op(2'd0, 1'b0, 3'd0, 1'b0, 32'h0101_01C0, "R8", 1'b0);
    run_op(2'd1, 1'b1, 3'd7, 1'b0, 32'h8000_0000, "R8", 1'b0);
    run_op(2'd2, 1'b0, 3'd5, 1'b0, 32'h8000_0000, "R8", 1'b0);

    // Start while busy is ignored
    run_op(2'd0, 1'b0, 3'd1, 1'b0, 32'h0000_0041, "R10", 1'b1);
    run_op(2'd1, 1'b1, 3'd3, 1'b1, 32'h00F0_0F0F, "R10", 1'b1);

    // Mixed patterns
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      run_op(a[1:0], a[2], a[5:3], a[6], lfsr, "R6", a[7]);
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R9", "jobs pending", TW'(sb.size()), '0);
    finish_run();
  end

endmodule